// File: doc/BRIEF.md
# Message Doorbell Interrupt Frame

This block sits between a bus master that raises message-signaled interrupts (for example a PCI host bridge) and an interrupt controller with a bank of shared peripheral lines. The master stores an interrupt number into a doorbell word inside a 4 KB register window. The frame removes the fixed offset of 32 and a configurable base, checks the result against the number of lines it owns, and raises the matching output line for exactly one clock cycle.

Software discovers the frame through a read-only type word, which reports the first interrupt number and the line count, and through an identification word. The top of the window is an identification space that reads as zero. Any access that is not a full-word, aligned, supported access is ignored and flagged for one cycle. A doorbell whose number falls outside the frame's range sets a sticky error flag that stays set until reset. Illegal parameter sets are rejected at elaboration.

The bus is evaluated every cycle; one state register records the outcome of the previous cycle's request and drives the flags. The states are IDLE (no request), READ (a supported read, data on the read bus), BELL (an accepted doorbell), REJECT (a full doorbell write outside the range) and BAD (any other access). From every state the next state is chosen by the current request alone: nothing goes to IDLE, a supported read goes to READ, an in-range doorbell goes to BELL, an out-of-range doorbell goes to REJECT, and everything else goes to BAD.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While and after reset, `irq_pulse`, `bus_rdata`, `range_err` and `bad_access` are all zero.
- R2: A full-word read at offset 0x008 returns, on the following cycle, `((BASE_LINE + 32) << 16) | NUM_LINES`, with bits [15:10] zero; elaboration fails unless 1 <= NUM_LINES <= 128 and BASE_LINE + 32 + NUM_LINES <= 1020.
- R3: A full-word read at offset 0xFCC returns 0x0510043B on the following cycle (product 0x051 in [31:20], zero revision in [19:16], implementer 0x43B in [11:0]).
- R4: Full-word aligned reads at offsets 0xFD4 through 0xFFC return zero and do not raise `bad_access`; offset 0xFD0 is not part of this space.
- R5: A full-word write at offset 0x040 whose low 10 data bits hold an ID in [BASE_LINE+32, BASE_LINE+32+NUM_LINES) raises `irq_pulse[ID-(BASE_LINE+32)]` for exactly the next cycle; data bits [31:10] have no effect.
- R6: A full-word doorbell write with an ID below or above that range raises no line; `range_err` is high from the next cycle until reset, and `bad_access` stays low.
- R7: An access with `bus_be` other than 4'b1111 reads as zero, changes nothing and raises `bad_access` for the next cycle.
- R8: Reads of the doorbell or of any unsupported or misaligned offset, writes to any offset other than 0x040, and cycles with both `bus_rd` and `bus_wr` set return zero, change nothing and raise `bad_access` for exactly the next cycle.
- R9: Doorbells to different lines on consecutive cycles pulse on consecutive cycles; two doorbells to the same line on consecutive cycles give a pulse, one low cycle, then a second pulse; a line is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, zero otherwise |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses toward the controller |
| range_err | output | 1 | Sticky out-of-range doorbell flag |
| bad_access | output | 1 | One-cycle flag for an unsupported access |

## Verification
The assertions assume that every bus strobe is a single-cycle request sampled at the rising edge and that the inputs carry known values after reset is released. The stimulus drives each request for exactly one cycle away from the clock edge and mixes seeded random doorbell numbers over the full 10-bit space, random byte-enable patterns and random offsets with directed cases at both range edges, consecutive doorbells, and combined read and write strobes. Random requests are separated by an idle cycle so each expected output is one request's result, while the directed cases cover back-to-back timing.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int          ID_W        = 10;
    localparam int          ID_OFFSET   = 32;
    localparam int          ID_LIMIT    = 1020;
    localparam int          LINES_MAX   = 128;

    localparam logic [11:0] OFS_TYPE    = 12'h008;
    localparam logic [11:0] OFS_BELL    = 12'h040;
    localparam logic [11:0] OFS_IDENT   = 12'hFCC;
    localparam logic [11:0] OFS_PID_LO  = 12'hFD4;

    localparam logic [11:0] PRODUCT_ID  = 12'h051;
    localparam logic [11:0] IMPLEMENTER = 12'h43B;
    localparam logic [3:0]  ARCH_REV    = 4'h0;

    // Classification of the request presented in the current cycle
    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_READ,
        REQ_BELL_HIT,
        REQ_BELL_MISS,
        REQ_BAD
    } req_kind_e;

    // Outcome recorded for the previous cycle
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_BELL,
        ST_REJECT,
        ST_BAD
    } frame_state_e;

    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_TYPE,
        RSEL_IDENT
    } read_sel_e;

    function automatic logic [31:0] ident_word();
        return {PRODUCT_ID, ARCH_REV, 4'h0, IMPLEMENTER};
    endfunction

    function automatic logic [31:0] type_word(input int base_line, input int num_lines);
        logic [31:0] first_id;
        logic [31:0] count;
        first_id = 32'(base_line + ID_OFFSET);
        count    = 32'(num_lines);
        return {first_id[15:0], 6'b0, count[9:0]};
    endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_frame_pkg::*;
#(
    parameter int BASE_LINE = 0,
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = 6
) (
    input  logic [11:0]      addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [3:0]       be,
    input  logic [ID_W-1:0]  bell_id,
    output req_kind_e        kind,
    output read_sel_e        rsel,
    output logic [IDX_W-1:0] line_idx
);

    localparam int FIRST_ID = BASE_LINE + ID_OFFSET;
    localparam int LAST_ID  = FIRST_ID + NUM_LINES;

    logic            full_word;
    logic            aligned;
    logic            in_range;
    logic [ID_W:0]   id_ext;
    logic [ID_W-1:0] rel_id;

    assign full_word = (be == 4'b1111);
    assign aligned   = (addr[1:0] == 2'b00);
    assign id_ext    = {1'b0, bell_id};
    assign in_range  = (id_ext >= (ID_W+1)'(FIRST_ID)) && (id_ext < (ID_W+1)'(LAST_ID));
    assign rel_id    = bell_id - ID_W'(FIRST_ID);
    assign line_idx  = rel_id[IDX_W-1:0];

    always_comb begin
        kind = REQ_NONE;
        rsel = RSEL_ZERO;
        if (wr && rd) begin
            kind = REQ_BAD;
        end else if (wr) begin
            if (full_word && addr == OFS_BELL) begin
                kind = in_range ? REQ_BELL_HIT : REQ_BELL_MISS;
            end else begin
                kind = REQ_BAD;
            end
        end else if (rd) begin
            if (!full_word || !aligned) begin
                kind = REQ_BAD;
            end else if (addr == OFS_TYPE) begin
                kind = REQ_READ;
                rsel = RSEL_TYPE;
            end else if (addr == OFS_IDENT) begin
                kind = REQ_READ;
                rsel = RSEL_IDENT;
            end else if (addr >= OFS_PID_LO) begin
                kind = REQ_READ;
                rsel = RSEL_ZERO;
            end else begin
                kind = REQ_BAD;
            end
        end
    end

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] pulse
);

    // Each line owns a pulse flop and a one-deep pending flop. A hit that
    // lands while the line is high is held over one low cycle.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit;
        logic want;
        logic pulse_q;
        logic pend_q;

        assign hit  = fire && (idx == IDX_W'(i));
        assign want = hit || pend_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pulse_q <= 1'b0;
                pend_q  <= 1'b0;
            end else begin
                pulse_q <= want && !pulse_q;
                pend_q  <= want && pulse_q;
            end
        end

        assign pulse[i] = pulse_q;
    end

endmodule

// File: rtl/msi_frame_ctrl.sv
module msi_frame_ctrl
    import msi_frame_pkg::*;
#(
    parameter logic [31:0] TYPE_WORD  = 32'h0,
    parameter logic [31:0] IDENT_WORD = 32'h0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  req_kind_e kind,
    input  read_sel_e rsel,
    output logic      fire,
    output logic [31:0] rdata,
    output logic      bad_access,
    output logic      range_err
);

    frame_state_e state_q;
    frame_state_e state_d;
    logic [31:0]  read_word;
    logic [31:0]  rdata_q;
    logic         err_q;

    always_comb begin
        unique case (kind)
            REQ_NONE:      state_d = ST_IDLE;
            REQ_READ:      state_d = ST_READ;
            REQ_BELL_HIT:  state_d = ST_BELL;
            REQ_BELL_MISS: state_d = ST_REJECT;
            REQ_BAD:       state_d = ST_BAD;
            default:       state_d = ST_BAD;
        endcase
    end

    always_comb begin
        unique case (rsel)
            RSEL_TYPE:  read_word = TYPE_WORD;
            RSEL_IDENT: read_word = IDENT_WORD;
            default:    read_word = 32'h0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 32'h0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= (state_d == ST_READ) ? read_word : 32'h0;
            err_q   <= err_q || (state_d == ST_REJECT);
        end
    end

    always_comb begin
        fire       = (state_d == ST_BELL);
        bad_access = (state_q == ST_BAD);
        rdata      = rdata_q;
        range_err  = err_q;
    end

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_LINE = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_pulse,
    output logic                 range_err,
    output logic                 bad_access
);

    localparam int          IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [31:0] TYPE_WORD  = type_word(BASE_LINE, NUM_LINES);
    localparam logic [31:0] IDENT_WORD = ident_word();

    // R2: reject illegal configurations at elaboration
    if (NUM_LINES < 1 || NUM_LINES > LINES_MAX ||
        BASE_LINE < 0 || BASE_LINE + ID_OFFSET + NUM_LINES > ID_LIMIT) begin : g_bad_config
        $error("msi_doorbell_frame: line count or base outside the legal interrupt range");
    end

    req_kind_e        kind;
    read_sel_e        rsel;
    logic [IDX_W-1:0] line_idx;
    logic             fire;
    logic [31:10]     unused_wdata_hi;

    assign unused_wdata_hi = bus_wdata[31:10];

    msi_frame_decode #(
        .BASE_LINE (BASE_LINE),
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .be       (bus_be),
        .bell_id  (bus_wdata[ID_W-1:0]),
        .kind     (kind),
        .rsel     (rsel),
        .line_idx (line_idx)
    );

    msi_frame_ctrl #(
        .TYPE_WORD  (TYPE_WORD),
        .IDENT_WORD (IDENT_WORD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .rsel       (rsel),
        .fire       (fire),
        .rdata      (bus_rdata),
        .bad_access (bad_access),
        .range_err  (range_err)
    );

    msi_pulse_bank #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .idx   (line_idx),
        .pulse (irq_pulse)
    );

endmodule

// File: rtl/msi_doorbell_frame_checker.sv
module msi_doorbell_frame_checker
    import msi_frame_pkg::*;
#(
    parameter int BASE_LINE = 0,
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [3:0]           bus_be,
    input logic [9:0]           bell_id,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] irq_pulse,
    input logic                 range_err,
    input logic                 bad_access
);

    localparam logic [10:0] FIRST_ID = 11'(BASE_LINE + ID_OFFSET);
    localparam logic [31:0] EXP_TYPE = ((32'(BASE_LINE) + 32'd32) << 16) | 32'(NUM_LINES);

    logic full_rd;
    logic full_wr;
    assign full_rd = bus_rd && !bus_wr && bus_be == 4'b1111;
    assign full_wr = bus_wr && !bus_rd && bus_be == 4'b1111;

    assert_type_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && bus_addr == 12'h008) |=> (bus_rdata == EXP_TYPE));

    assert_ident_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && bus_addr == 12'hFCC) |=> (bus_rdata == 32'h0510043B));

    assert_pid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && bus_addr >= 12'hFD4 && bus_addr[1:0] == 2'b00) |=> (bus_rdata == 32'h0 && !bad_access));

    assert_low_id_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr == 12'h040 && {1'b0, bell_id} < FIRST_ID) |=> (range_err && !bad_access));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    assert_partial_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_be != 4'b1111) |=> bad_access);

    assert_bad_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> (bus_rdata == 32'h0));

    assert_no_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_pulse & $past(irq_pulse)) == '0));

endmodule

bind msi_doorbell_frame msi_doorbell_frame_checker #(
    .BASE_LINE (BASE_LINE),
    .NUM_LINES (NUM_LINES)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_be     (bus_be),
    .bell_id    (bus_wdata[9:0]),
    .bus_rdata  (bus_rdata),
    .irq_pulse  (irq_pulse),
    .range_err  (range_err),
    .bad_access (bad_access)
);

// File: tb/msi_doorbell_frame_test.sv
`timescale 1ns/1ps
module msi_doorbell_frame_test;

    localparam int BASE  = 5;
    localparam int NUM   = 40;
    localparam int FIRST = BASE + 32;
    localparam logic [31:0] TYPE_EXP  = 32'h00250028;
    localparam logic [31:0] IDENT_EXP = 32'h0510043B;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [3:0]      bus_be = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NUM-1:0]  irq_pulse;
    logic            range_err;
    logic            bad_access;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;
    logic err_exp = 1'b0;

    always #5 clk = ~clk;

    msi_doorbell_frame #(.BASE_LINE(BASE), .NUM_LINES(NUM)) uut (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_be, .bus_wdata,
        .bus_rdata, .irq_pulse, .range_err, .bad_access
    );

    function automatic logic [NUM-1:0] line_of(input int id);
        logic [NUM-1:0] one = 1;
        if (id >= FIRST && id < FIRST + NUM) return one << (id - FIRST);
        return '0;
    endfunction

    function automatic bit id_in_range(input int id);
        return (id >= FIRST && id < FIRST + NUM);
    endfunction

    function automatic bit read_ok(input logic [11:0] a);
        return (a == 12'h008) || (a == 12'hFCC) || (a >= 12'hFD4 && a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] read_val(input logic [11:0] a);
        if (a == 12'h008) return TYPE_EXP;
        if (a == 12'hFCC) return IDENT_EXP;
        return 32'h0;
    endfunction

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [NUM-1:0] p, input logic [31:0] rd,
                              input logic bad, input logic err);
        cmp(req, "irq_pulse", 64'(irq_pulse), 64'(p));
        cmp(req, "bus_rdata", 64'(bus_rdata), 64'(rd));
        cmp(req, "bad_access", 64'(bad_access), 64'(bad));
        cmp(req, "range_err", 64'(range_err), 64'(err));
    endtask

    task automatic put(input logic w, input logic r, input logic [11:0] a, input logic [3:0] be,
                       input logic [31:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_be = be; bus_wdata = d;
    endtask

    task automatic idle();
        put(1'b0, 1'b0, 12'h000, 4'h0, 32'h0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bell(input int id);
        put(1'b1, 1'b0, 12'h040, 4'hF, 32'(id));
    endtask

    task automatic read_at(input logic [11:0] a);
        put(1'b0, 1'b1, a, 4'hF, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) tick();
        expect_out("R1", '0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        expect_out("R1", '0, 32'h0, 1'b0, 1'b0);

        // R2 type word
        read_at(12'h008); tick(); idle();
        expect_out("R2", '0, TYPE_EXP, 1'b0, 1'b0);
        cmp("R2", "type bits 15:10", 64'(bus_rdata[15:10]), 64'h0);
        tick();
        expect_out("R2", '0, 32'h0, 1'b0, 1'b0);

        // R3 identification word
        read_at(12'hFCC); tick(); idle();
        expect_out("R3", '0, IDENT_EXP, 1'b0, 1'b0);

        // R4 identification space edges
        read_at(12'hFD4); tick(); read_at(12'hFFC);
        expect_out("R4", '0, 32'h0, 1'b0, 1'b0);
        tick(); read_at(12'hFD0);
        expect_out("R4", '0, 32'h0, 1'b0, 1'b0);
        tick(); idle();
        expect_out("R4 0xFD0 is bad", '0, 32'h0, 1'b1, 1'b0);
        tick();

        // R5 range edges and ignored upper data bits
        bell(FIRST); tick(); idle();
        expect_out("R5 first line", line_of(FIRST), 32'h0, 1'b0, 1'b0);
        tick();
        expect_out("R5 single cycle", '0, 32'h0, 1'b0, 1'b0);
        bell(FIRST + NUM - 1); tick(); idle();
        expect_out("R5 last line", line_of(FIRST + NUM - 1), 32'h0, 1'b0, 1'b0);
        tick();
        put(1'b1, 1'b0, 12'h040, 4'hF, 32'hFFFF_FC00 | 32'(FIRST + 3)); tick(); idle();
        expect_out("R5 upper bits", line_of(FIRST + 3), 32'h0, 1'b0, 1'b0);
        tick();

        // R7 partial byte enables
        put(1'b1, 1'b0, 12'h040, 4'h3, 32'(FIRST + 1)); tick(); idle();
        expect_out("R7 partial write", '0, 32'h0, 1'b1, 1'b0);
        tick();
        expect_out("R7 no late pulse", '0, 32'h0, 1'b0, 1'b0);
        put(1'b0, 1'b1, 12'h008, 4'h1, 32'h0); tick(); idle();
        expect_out("R7 partial read", '0, 32'h0, 1'b1, 1'b0);
        tick();

        // R8 bad accesses
        put(1'b0, 1'b1, 12'h040, 4'hF, 32'h0); tick();
        put(1'b1, 1'b0, 12'h008, 4'hF, 32'(FIRST));
        expect_out("R8 doorbell read", '0, 32'h0, 1'b1, 1'b0);
        tick(); put(1'b0, 1'b1, 12'h009, 4'hF, 32'h0);
        expect_out("R8 type write", '0, 32'h0, 1'b1, 1'b0);
        tick(); put(1'b1, 1'b1, 12'h040, 4'hF, 32'(FIRST));
        expect_out("R8 misaligned", '0, 32'h0, 1'b1, 1'b0);
        tick(); put(1'b1, 1'b0, 12'h044, 4'hF, 32'(FIRST));
        expect_out("R8 rd and wr", '0, 32'h0, 1'b1, 1'b0);
        tick(); idle();
        expect_out("R8 unmapped write", '0, 32'h0, 1'b1, 1'b0);
        tick();
        expect_out("R8 one cycle", '0, 32'h0, 1'b0, 1'b0);

        // R9 back to back
        bell(FIRST + 3); tick(); bell(FIRST + 13);
        expect_out("R9 diff first", line_of(FIRST + 3), 32'h0, 1'b0, 1'b0);
        tick(); idle();
        expect_out("R9 diff second", line_of(FIRST + 13), 32'h0, 1'b0, 1'b0);
        tick();
        expect_out("R9 diff end", '0, 32'h0, 1'b0, 1'b0);
        bell(FIRST + 7); tick(); bell(FIRST + 7);
        expect_out("R9 same first", line_of(FIRST + 7), 32'h0, 1'b0, 1'b0);
        tick(); idle();
        expect_out("R9 same gap", '0, 32'h0, 1'b0, 1'b0);
        tick();
        expect_out("R9 same second", line_of(FIRST + 7), 32'h0, 1'b0, 1'b0);
        tick();
        expect_out("R9 same end", '0, 32'h0, 1'b0, 1'b0);

        // R6 out of range, both sides
        bell(FIRST - 1); tick(); idle();
        expect_out("R6 below", '0, 32'h0, 1'b0, 1'b1);
        tick();
        expect_out("R6 sticky", '0, 32'h0, 1'b0, 1'b1);
        bell(FIRST + NUM); tick(); idle();
        expect_out("R6 above", '0, 32'h0, 1'b0, 1'b1);
        tick();
        err_exp = 1'b1;

        // Random phase
        for (int n = 0; n < 300; n++) begin
            int unsigned sel = $urandom % 4;
            if (sel < 2) begin
                int id = (($urandom % 2) == 0) ? (FIRST + int'($urandom % NUM)) : int'($urandom % 1024);
                logic [3:0] be = (($urandom % 8) == 0) ? 4'($urandom % 15) : 4'hF;
                logic [31:0] d = {$urandom} & 32'hFFFF_FC00 | 32'(id);
                bit ok = (be == 4'hF);
                put(1'b1, 1'b0, 12'h040, be, d); tick(); idle();
                if (ok && !id_in_range(id)) err_exp = 1'b1;
                expect_out(ok ? (id_in_range(id) ? "R5 random" : "R6 random") : "R7 random",
                           ok ? line_of(id) : '0, 32'h0, !ok, err_exp);
            end else begin
                logic [11:0] a = (sel == 2) ? 12'($urandom % 4096)
                                            : ((($urandom % 2) == 0) ? 12'h008 : 12'hFD0 + 12'(4 * ($urandom % 12)));
                bit ok = read_ok(a);
                read_at(a); tick(); idle();
                expect_out(ok ? "R2 R3 R4 random read" : "R8 random read",
                           '0, ok ? read_val(a) : 32'h0, !ok, err_exp);
            end
            tick();
            expect_out("R9 random idle", '0, 32'h0, 1'b0, err_exp);
        end

        // R1 reset clears the sticky flag
        rst_n = 1'b0; #1;
        expect_out("R1 reapplied", '0, 32'h0, 1'b0, 1'b0);
        tick();
        rst_n = 1'b1;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule